// File: doc/BRIEF.md
# Packed SIMD Signed Averaging Adder

This block takes two 64-bit packed words and splits them into signed elements of 8, 16, 32 or 64 bits. For each element it forms half the sum or half the difference of the two operands. The result always fits in the element because the intermediate value keeps one extra bit. The one bit that the halving drops is turned into a rounding increment by one of four rounding modes. The second operand is either the matching element of a second packed word or one scalar value that is copied into every element.

A per-element mask selects which elements receive the new value. Masked-off elements keep the element of an old destination word that comes in with the operation. One operation can be accepted on every clock. The result appears on a registered output one cycle after the input strobe. The caller supplies everything per operation: element width, operation, rounding mode, operand form and mask.

The narrower element widths use an adder one bit wider than the element. The full 64-bit element uses a 64-bit adder and rebuilds the missing top bit from the signed-overflow condition.

Top module: `simd_avg_unit`

## Requirements
- R1: `elem_w` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Element i occupies bits [i*W +: W]. Elements are computed independently, with no carry or borrow crossing an element boundary.
- R2: With `op_sub`=0, each element is the exact signed sum a+b arithmetically shifted right by one, plus the rounding increment.
- R3: With `op_sub`=1, each element is the exact signed difference a-b arithmetically shifted right by one, plus the rounding increment.
- R4: Let d be bit 0 of the exact sum or difference (the dropped bit) and h bit 0 of the halved value. The increment is d for `rnd_mode`=0, d AND h for 1, 0 for 2, and d AND NOT h for 3.
- R5: The element result is the low W bits of (halved value + increment). The single case that exceeds the element (difference of most-positive and most-negative with the increment set) wraps to the most-negative value.
- R6: With `use_scalar`=1, the low W bits of `scalar` are the second operand of every element and `src_b` has no effect.
- R7: `out_valid` is `in_valid` delayed by one clock. `out_data` is loaded only when `in_valid` is high and holds otherwise. A synchronous active-high `rst` clears both to zero.
- R8: With `mask_en`=1, element i is written only when `mask[i]` is 1; otherwise the element from `old_dst` is passed through. With `mask_en`=0 every element is written and `mask` is ignored.
- R9: 64-bit elements give the exact result for all operands, including sums and differences of the extreme values that overflow 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 selects averaging add, 1 selects averaging subtract |
| use_scalar | input | 1 | 1 broadcasts `scalar` as the second operand |
| elem_w | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64) |
| rnd_mode | input | 2 | Rounding mode (0 nearest-up, 1 nearest-even, 2 truncate, 3 odd) |
| mask_en | input | 1 | Enables per-element write mask |
| mask | input | 8 | Per-element write enables, bit i for element i |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| scalar | input | 64 | Scalar second operand, truncated to the element width |
| old_dst | input | 64 | Prior destination word for masked-off elements |
| out_valid | output | 1 | Result strobe |
| out_data | output | 64 | Packed result |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath with an 8-bit minimum element. That gives four element widths, eight mask bits, and a full-width element that goes through the overflow-recovery adder rather than the widened one. Every width is paired with both operations, all four rounding modes and both operand forms, using extreme-value and pseudo-random operands. This covers the wrap-around case at each width and the 64-bit sums whose carry-out would otherwise be lost. Mask patterns are tried with masking enabled and disabled.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'd0,
    RND_NEAR_EVEN = 2'd1,
    RND_TRUNC     = 2'd2,
    RND_ODD       = 2'd3
  } rnd_mode_e;

  // Increment applied to the halved value: dropped is the bit shifted out,
  // kept_lsb is bit 0 of the halved value.
  function automatic logic rnd_inc(rnd_mode_e m, logic dropped, logic kept_lsb);
    logic inc;
    unique case (m)
      RND_NEAR_UP:   inc = dropped;
      RND_NEAR_EVEN: inc = dropped & kept_lsb;
      RND_ODD:       inc = dropped & ~kept_lsb;
      default:       inc = 1'b0;
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/simd_avg_lane.sv
module simd_avg_lane
  import simd_avg_pkg::*;
#(
  parameter int W    = 8,
  parameter bit FULL = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  rnd_mode_e    rm,
  output logic [W-1:0] res
);

  logic [W-1:0] half;
  logic         dropped;

  generate
    if (FULL) begin : g_full
      // W-bit adder; the lost top bit is rebuilt from signed overflow.
      logic [W-1:0] raw;
      logic         ovf;
      always_comb begin
        raw     = sub ? (a - b) : (a + b);
        ovf     = sub ? ((raw[W-1] ^ a[W-1]) & (a[W-1] ^ b[W-1]))
                      : ((raw[W-1] ^ a[W-1]) & (raw[W-1] ^ b[W-1]));
        half    = {raw[W-1] ^ ovf, raw[W-1:1]};
        dropped = raw[0];
      end
    end else begin : g_wide
      // One guard bit of extra width keeps the exact value.
      logic [W:0] ext_a;
      logic [W:0] ext_b;
      logic [W:0] raw;
      always_comb begin
        ext_a   = {a[W-1], a};
        ext_b   = {b[W-1], b};
        raw     = sub ? (ext_a - ext_b) : (ext_a + ext_b);
        half    = raw[W:1];
        dropped = raw[0];
      end
    end
  endgenerate

  assign res = half + {{(W-1){1'b0}}, rnd_inc(rm, dropped, half[0])};

endmodule

// File: rtl/simd_avg_slice.sv
module simd_avg_slice
  import simd_avg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EW     = 8
) (
  input  logic [DATA_W-1:0]      src_a,
  input  logic [DATA_W-1:0]      src_b,
  input  logic [EW-1:0]          scalar,
  input  logic [DATA_W-1:0]      old_dst,
  input  logic                   use_scalar,
  input  logic                   sub,
  input  rnd_mode_e              rm,
  input  logic                   mask_en,
  input  logic [DATA_W/EW-1:0]   mask,
  output logic [DATA_W-1:0]      res
);

  localparam int  N    = DATA_W / EW;
  localparam bit  FULL = (EW == DATA_W);

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [EW-1:0] opnd_b;
    logic [EW-1:0] lane_res;
    logic          keep_old;

    assign opnd_b   = use_scalar ? scalar : src_b[i*EW +: EW];
    assign keep_old = mask_en & ~mask[i];

    simd_avg_lane #(.W(EW), .FULL(FULL)) u_lane (
      .a   (src_a[i*EW +: EW]),
      .b   (opnd_b),
      .sub (sub),
      .rm  (rm),
      .res (lane_res)
    );

    assign res[i*EW +: EW] = keep_old ? old_dst[i*EW +: EW] : lane_res;
  end

endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
  import simd_avg_pkg::*;
#(
  parameter  int DATA_W = 64,
  parameter  int MIN_EW = 8,
  localparam int NUM_W  = $clog2(DATA_W / MIN_EW) + 1,
  localparam int SEL_W  = (NUM_W > 1) ? $clog2(NUM_W) : 1,
  localparam int MASK_W = DATA_W / MIN_EW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic              use_scalar,
  input  logic [SEL_W-1:0]  elem_w,
  input  logic [1:0]        rnd_mode,
  input  logic              mask_en,
  input  logic [MASK_W-1:0] mask,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] scalar,
  input  logic [DATA_W-1:0] old_dst,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] slice_res [NUM_W];
  logic [DATA_W-1:0] sel_res;
  rnd_mode_e         rm;

  assign rm = rnd_mode_e'(rnd_mode);

  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    localparam int EW = MIN_EW << g;
    simd_avg_slice #(.DATA_W(DATA_W), .EW(EW)) u_slice (
      .src_a      (src_a),
      .src_b      (src_b),
      .scalar     (scalar[EW-1:0]),
      .old_dst    (old_dst),
      .use_scalar (use_scalar),
      .sub        (op_sub),
      .rm         (rm),
      .mask_en    (mask_en),
      .mask       (mask[DATA_W/EW-1:0]),
      .res        (slice_res[g])
    );
  end

  always_comb begin
    sel_res = old_dst;
    for (int k = 0; k < NUM_W; k++) begin
      if (int'(elem_w) == k) sel_res = slice_res[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sel_res;
    end
  end

  // R7: strobe follows input by exactly one cycle
  a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r7_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R2: averaging equal operands returns the operand at any width and mode
  a_r2_equal_add: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sub && !use_scalar && !mask_en && src_a == src_b)
    |=> out_data == $past(src_a));

  // R3: half the difference of equal operands is zero
  a_r3_equal_sub: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sub && !use_scalar && !mask_en && src_a == src_b)
    |=> out_data == '0);

  // R8: a masked-off smallest element passes the old destination through
  a_r8_mask_keep: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !mask[0] && elem_w == '0)
    |=> out_data[MIN_EW-1:0] == $past(old_dst[MIN_EW-1:0]));

endmodule

// File: tb/simd_avg_unit_tb.sv
module simd_avg_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic        use_scalar = 1'b0;
  logic [1:0]  elem_w = '0;
  logic [1:0]  rnd_mode = '0;
  logic        mask_en = 1'b0;
  logic [7:0]  mask = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] scalar = '0;
  logic [63:0] old_dst = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;
  item_t       q[$];
  logic [63:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_avg_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .use_scalar(use_scalar), .elem_w(elem_w), .rnd_mode(rnd_mode),
    .mask_en(mask_en), .mask(mask), .src_a(src_a), .src_b(src_b),
    .scalar(scalar), .old_dst(old_dst), .out_valid(out_valid),
    .out_data(out_data)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic signed [65:0] sext(logic [63:0] v, int w);
    logic signed [65:0] x;
    x = $signed({2'b00, v}) <<< (66 - w);
    return x >>> (66 - w);
  endfunction

  function automatic logic [63:0] fill(int w, logic [63:0] v);
    logic [63:0] r = '0;
    for (int i = 0; i < 64 / w; i++) r = r | ((v & lmask(w)) << (i * w));
    return r;
  endfunction

  function automatic logic [63:0] lmask(int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  // Reference model from the requirements, in 66-bit signed arithmetic.
  function automatic logic [63:0] ref_avg(bit sub, bit scal, logic [1:0] ew,
      logic [1:0] rm, bit men, logic [7:0] m, logic [63:0] a, logic [63:0] b,
      logic [63:0] sc, logic [63:0] old);
    int w = 8 << ew;
    logic [63:0] r = '0;
    for (int i = 0; i < 64 / w; i++) begin
      logic signed [65:0] ea, eb, s, h;
      logic inc;
      logic [63:0] lane;
      ea = sext(a >> (i * w), w);
      eb = scal ? sext(sc, w) : sext(b >> (i * w), w);
      s  = sub ? (ea - eb) : (ea + eb);
      h  = s >>> 1;
      case (rm)
        2'd0: inc = s[0];
        2'd1: inc = s[0] & h[0];
        2'd2: inc = 1'b0;
        default: inc = s[0] & ~h[0];
      endcase
      h = h + 66'(inc);
      lane = (men && !m[i]) ? ((old >> (i * w)) & lmask(w)) : (h[63:0] & lmask(w));
      r = r | (lane << (i * w));
    end
    return r;
  endfunction

  task automatic send(bit sub, bit scal, logic [1:0] ew, logic [1:0] rm,
      bit men, logic [7:0] m, logic [63:0] a, logic [63:0] b,
      logic [63:0] sc, logic [63:0] old, string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; op_sub = sub; use_scalar = scal; elem_w = ew;
    rnd_mode = rm; mask_en = men; mask = m; src_a = a; src_b = b;
    scalar = sc; old_dst = old;
    it.exp = ref_avg(sub, scal, ew, rm, men, m, a, b, sc, old);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pops expected results as the design produces them.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q.size() == 0) begin
          check("R7 unexpected output", out_data, 64'hx);
        end else begin
          item_t it;
          it = q.pop_front();
          check(it.tag, out_data, it.exp);
          last_exp = it.exp;
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    check("R7 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R7 reset out_data", out_data, 64'd0);

    for (int ew = 0; ew < 4; ew++) begin
      int w = 8 << ew;
      logic [63:0] mx = fill(w, (64'd1 << (w - 1)) - 64'd1);
      logic [63:0] mn = fill(w, 64'd1 << (w - 1));
      logic [63:0] m1 = '1;
      for (int sub = 0; sub < 2; sub++) begin
        for (int rm = 0; rm < 4; rm++) begin
          string tg;
          tg = (ew == 3) ? "R9 full width" : (sub != 0) ? "R3 sub" : "R2 add";
          send(sub[0], 1'b0, ew[1:0], rm[1:0], 1'b0, 8'h00, mx, mx, 64'd0, 64'd0, tg);
          send(sub[0], 1'b0, ew[1:0], rm[1:0], 1'b0, 8'h00, mn, mn, 64'd0, 64'd0, tg);
          send(sub[0], 1'b0, ew[1:0], rm[1:0], 1'b0, 8'h00, mx, mn, 64'd0, 64'd0, "R5 wrap");
          send(sub[0], 1'b0, ew[1:0], rm[1:0], 1'b0, 8'h00, mn, mx, 64'd0, 64'd0, tg);
          send(sub[0], 1'b0, ew[1:0], rm[1:0], 1'b0, 8'h00, mn, m1, 64'd0, 64'd0, tg);
          send(sub[0], 1'b0, ew[1:0], rm[1:0], 1'b0, 8'h00,
               fill(w, 64'd3), fill(w, 64'd0), 64'd0, 64'd0, "R4 rounding odd sum");
          send(sub[0], 1'b0, ew[1:0], rm[1:0], 1'b0, 8'h00,
               fill(w, 64'd1), fill(w, 64'd0), 64'd0, 64'd0, "R4 rounding even half");
          send(sub[0], 1'b0, ew[1:0], rm[1:0], 1'b0, 8'h00,
               {$urandom, $urandom}, {$urandom, $urandom}, 64'd0, 64'd0, "R1 lanes random");
          send(sub[0], 1'b1, ew[1:0], rm[1:0], 1'b0, 8'h00,
               {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
               64'd0, "R6 scalar");
          send(sub[0], 1'b1, ew[1:0], rm[1:0], 1'b0, 8'h00,
               mn, 64'd0, mx, 64'd0, "R6 scalar extreme");
        end
      end
      // R1: values that would carry across lane boundaries
      send(1'b0, 1'b0, ew[1:0], 2'd0, 1'b0, 8'h00, mx, fill(w, 64'd1),
           64'd0, 64'd0, "R1 no cross-lane carry");
      send(1'b1, 1'b0, ew[1:0], 2'd0, 1'b0, 8'h00, fill(w, 64'd0), fill(w, 64'd1),
           64'd0, 64'd0, "R1 no cross-lane borrow");
      // R8: masking
      for (int k = 0; k < 4; k++) begin
        send(k[0], 1'b0, ew[1:0], k[1:0], 1'b1, 8'($urandom),
             {$urandom, $urandom}, {$urandom, $urandom}, 64'd0,
             {$urandom, $urandom}, "R8 masked");
      end
      send(1'b0, 1'b0, ew[1:0], 2'd2, 1'b1, 8'h00, mx, mx, 64'd0,
           64'hA5A5_5A5A_0F0F_F0F0, "R8 all masked");
      send(1'b0, 1'b0, ew[1:0], 2'd2, 1'b0, 8'h00, mx, mn, 64'd0,
           64'hA5A5_5A5A_0F0F_F0F0, "R8 mask ignored");
    end

    idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    // R7: output holds while idle
    check("R7 idle out_valid", {63'd0, out_valid}, 64'd0);
    check("R7 idle hold", out_data, last_exp);
    // R7: reset clears a loaded result
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 reset clears data", out_data, 64'd0);
    finish_run();
  end

endmodule